// File: doc/BRIEF.md
# SDRAM Command Spacing Gate

This block sits between an SDRAM command scheduler and the memory command pins. The scheduler offers one command at a time (activate, read, write, precharge or auto refresh) with a bank and an address over a valid/ready handshake. The block holds the offer back until every programmed minimum spacing since the earlier commands it depends on has passed. It then registers the command, bank and address onto the pins and raises a bank select strobe either in the same cycle or one cycle later.

The spacings come from a single 10-bit timing word. Each field holds a small code, not a raw cycle count. Two of the codes are reserved. When one of them is written, a sticky error output rises and no further command is accepted until a clean word is written. The refresh-to-activate and read/write-to-precharge spacings are tracked globally. The activate-to-read/write and precharge-to-activate spacings are tracked separately for each of the four banks.

Top module: `sdram_cmd_timer`

## Requirements
- R1: After reset, `req_ready` is high for a NOP offer, `mem_cmd` is NOP, `mem_bank_sel` is low and `config_error` is low. The reset timing word selects 4, 2, 1 and 1 cycles, with a leadoff of 0.
- R2: A read (code 2) or write (code 3) to a bank is accepted no sooner than N clock edges after that bank's activate (code 1). N comes from timing word bits [4:3], where 01, 10 and 11 select 2, 3 and 4. An activate to one bank does not delay reads or writes to another bank.
- R3: An activate is accepted no sooner than N edges after the last auto refresh (code 5). N is 4 plus the code held in timing word bits [2:0], for codes 0 to 6.
- R4: A precharge (code 4) is accepted no sooner than N edges after the last read or write to any bank. N is 1 plus the code held in bits [6:5].
- R5: An activate to a bank is accepted no sooner than N edges after that bank's precharge. N is 1 plus the code held in bits [8:7].
- R6: When timing word bit 9 is 0, `mem_bank_sel` rises in the same cycle that the command appears on `mem_cmd`. When bit 9 is 1, it rises one cycle later. Command, bank and address stay unchanged through that cycle, and no offer is accepted during it.
- R7: In every cycle that carries no issued command, `mem_cmd` is NOP (code 0) and `mem_bank_sel` is low. Each accepted command produces exactly one strobe cycle, carrying its own command, bank and address.
- R8: Writing a timing word with bits [2:0] = 111 or bits [4:3] = 00 sets `config_error` from the next cycle. The error stays set, `req_ready` stays low and no command reaches the pins until a word free of reserved codes is written. That write clears the error.
- R9: When a timing word write and an accepted command share a clock edge, the spacing that command starts uses the old word. Later commands use the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Timing word write strobe |
| cfg_wdata | input | 10 | Timing word value |
| req_valid | input | 1 | Command offer valid |
| req_ready | output | 1 | Offer accepted on this edge when valid |
| req_cmd | input | 3 | Offered command code |
| req_bank | input | 2 | Offered bank |
| req_addr | input | 13 | Offered row or column address |
| mem_cmd | output | 3 | Command code on the pins |
| mem_bank | output | 2 | Bank on the pins |
| mem_addr | output | 13 | Address on the pins |
| mem_bank_sel | output | 1 | Bank select strobe |
| config_error | output | 1 | Sticky reserved-code flag |

## Verification
Two functions can fall on the same clock edge: a timing word write and the acceptance of a command whose spacing counter is loaded from that word. The bench provokes this by raising `cfg_wr` in the cycle an activate is offered with no stall pending. The new word shortens activate-to-read from four cycles to two. The following read must still stall three cycles, which shows that the old value loaded the counter. A later activate/read pair on another bank must then stall one cycle, which shows that the new value took effect.

// File: rtl/sdram_tim_pkg.sv
package sdram_tim_pkg;

    localparam int CNT_W = 4;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5
    } cmd_e;

    // Timing word, MSB first: leadoff[9], pre2act[8:7], rw2pre[6:5], act2rw[4:3], ref2act[2:0]
    typedef struct packed {
        logic       leadoff;
        logic [1:0] pre2act;
        logic [1:0] rw2pre;
        logic [1:0] act2rw;
        logic [2:0] ref2act;
    } tcfg_t;

    localparam int CFG_W = $bits(tcfg_t);

    localparam tcfg_t TCFG_RESET = '{leadoff: 1'b0, pre2act: 2'b00, rw2pre: 2'b00,
                                     act2rw: 2'b01, ref2act: 3'b000};

    // Counter load values are (minimum spacing - 1)
    function automatic logic [CNT_W-1:0] ref_load(input logic [2:0] code);
        return {1'b0, code} + 4'd3;
    endfunction

    function automatic logic [CNT_W-1:0] two_bit_load(input logic [1:0] code);
        return {2'b00, code};
    endfunction

    function automatic logic cfg_reserved(input tcfg_t c);
        return (c.ref2act == 3'b111) || (c.act2rw == 2'b00);
    endfunction

endpackage

// File: rtl/sdram_tim_cfg.sv
module sdram_tim_cfg
    import sdram_tim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output tcfg_t            cfg,
    output logic             cfg_err
);

    tcfg_t wr_word;
    assign wr_word = tcfg_t'(wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= TCFG_RESET;
            cfg_err <= 1'b0;
        end else if (wr_en) begin
            cfg     <= wr_word;
            cfg_err <= cfg_reserved(wr_word);
        end
    end

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_err && !wr_en) |=> cfg_err);

endmodule

// File: rtl/sdram_tim_gate.sv
module sdram_tim_gate
    import sdram_tim_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  cmd_e              cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic [2:0]        ref2act_code,
    input  logic [1:0]        act2rw_code,
    input  logic [1:0]        rw2pre_code,
    input  logic [1:0]        pre2act_code,
    output logic              clear
);

    logic [CNT_W-1:0]     ref_cnt;
    logic [CNT_W-1:0]     rwp_cnt;
    logic [NUM_BANKS-1:0] act_done;
    logic [NUM_BANKS-1:0] pre_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_cnt <= '0;
            rwp_cnt <= '0;
        end else begin
            if (fire && cmd == CMD_REF)     ref_cnt <= ref_load(ref2act_code);
            else if (ref_cnt != '0)         ref_cnt <= ref_cnt - 1'b1;
            if (fire && (cmd == CMD_RD || cmd == CMD_WR))
                                            rwp_cnt <= two_bit_load(rw2pre_code);
            else if (rwp_cnt != '0)         rwp_cnt <= rwp_cnt - 1'b1;
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [CNT_W-1:0] act_cnt;
        logic [CNT_W-1:0] pre_cnt;
        logic             hit;
        assign hit = fire && (bank == BANK_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                act_cnt <= '0;
                pre_cnt <= '0;
            end else begin
                if (hit && cmd == CMD_ACT)  act_cnt <= two_bit_load(act2rw_code);
                else if (act_cnt != '0)     act_cnt <= act_cnt - 1'b1;
                if (hit && cmd == CMD_PRE)  pre_cnt <= two_bit_load(pre2act_code);
                else if (pre_cnt != '0)     pre_cnt <= pre_cnt - 1'b1;
            end
        end

        assign act_done[b] = (act_cnt == '0);
        assign pre_done[b] = (pre_cnt == '0);
    end

    always_comb begin
        unique case (cmd)
            CMD_ACT:        clear = (ref_cnt == '0) && pre_done[bank];
            CMD_RD, CMD_WR: clear = act_done[bank];
            CMD_PRE:        clear = (rwp_cnt == '0);
            default:        clear = 1'b1;
        endcase
    end

    // Independent watch of refresh-to-activate distance
    logic [CNT_W:0] chk_since_ref;
    logic [CNT_W:0] chk_need;
    logic           chk_seen_ref;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_since_ref <= '0;
            chk_need      <= '0;
            chk_seen_ref  <= 1'b0;
        end else if (fire && cmd == CMD_REF) begin
            chk_since_ref <= (CNT_W+1)'(1);
            chk_need      <= (CNT_W+1)'(ref2act_code) + (CNT_W+1)'(4);
            chk_seen_ref  <= 1'b1;
        end else if (chk_since_ref != '1) begin
            chk_since_ref <= chk_since_ref + 1'b1;
        end
    end

    assert_ref_to_act_R3: assert property (@(posedge clk) disable iff (rst)
        (fire && cmd == CMD_ACT && chk_seen_ref) |-> (chk_since_ref >= chk_need));

endmodule

// File: rtl/sdram_tim_drive.sv
module sdram_tim_drive
    import sdram_tim_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  cmd_e              cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] addr,
    input  logic              lead,
    output cmd_e              out_cmd,
    output logic [BANK_W-1:0] out_bank,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_sel,
    output logic              busy
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_cmd  <= CMD_NOP;
            out_bank <= '0;
            out_addr <= '0;
            out_sel  <= 1'b0;
            busy     <= 1'b0;
        end else if (fire) begin
            out_cmd  <= cmd;
            out_bank <= bank;
            out_addr <= addr;
            out_sel  <= !lead;
            busy     <= lead;
        end else if (busy) begin
            out_sel  <= 1'b1;
            busy     <= 1'b0;
        end else begin
            out_cmd  <= CMD_NOP;
            out_sel  <= 1'b0;
        end
    end

    assert_lead_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (fire && lead) |=> (!out_sel && busy) ##1
                           (out_sel && $stable(out_cmd) && $stable(out_addr) && $stable(out_bank)));

    assert_sel_needs_cmd_R7: assert property (@(posedge clk) disable iff (rst)
        out_sel |-> (out_cmd != CMD_NOP));

endmodule

// File: rtl/sdram_cmd_timer.sv
module sdram_cmd_timer
    import sdram_tim_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_cmd,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [2:0]        mem_cmd,
    output logic [BANK_W-1:0] mem_bank,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_bank_sel,
    output logic              config_error
);

    tcfg_t cfg;
    cmd_e  cmd_in;
    cmd_e  cmd_out;
    logic  spacing_ok;
    logic  lead_busy;
    logic  fire;

    assign cmd_in    = cmd_e'(req_cmd);
    assign req_ready = !config_error && !lead_busy && spacing_ok;
    assign fire      = req_valid && req_ready;
    assign mem_cmd   = cmd_out;

    sdram_tim_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .wr_data (cfg_wdata),
        .cfg     (cfg),
        .cfg_err (config_error)
    );

    sdram_tim_gate #(.NUM_BANKS(NUM_BANKS)) u_gate (
        .clk          (clk),
        .rst          (rst),
        .fire         (fire),
        .cmd          (cmd_in),
        .bank         (req_bank),
        .ref2act_code (cfg.ref2act),
        .act2rw_code  (cfg.act2rw),
        .rw2pre_code  (cfg.rw2pre),
        .pre2act_code (cfg.pre2act),
        .clear        (spacing_ok)
    );

    sdram_tim_drive #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_drive (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .cmd      (cmd_in),
        .bank     (req_bank),
        .addr     (req_addr),
        .lead     (cfg.leadoff),
        .out_cmd  (cmd_out),
        .out_bank (mem_bank),
        .out_addr (mem_addr),
        .out_sel  (mem_bank_sel),
        .busy     (lead_busy)
    );

    assert_error_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        config_error |-> !req_ready);

    assert_error_no_issue_R8: assert property (@(posedge clk) disable iff (rst)
        (config_error && !lead_busy) |=> (mem_cmd == 3'd0));

endmodule

// File: tb/sdram_cmd_timer_tb.sv
`timescale 1ns/1ps
module sdram_cmd_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [9:0]  cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_cmd = 3'd0;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_addr = '0;
    logic [2:0]  mem_cmd;
    logic [1:0]  mem_bank;
    logic [12:0] mem_addr;
    logic        mem_bank_sel;
    logic        config_error;

    int errors = 0;
    int checks = 0;
    logic lead_mode = 1'b0;

    typedef struct {
        logic [2:0]  cmd;
        logic [1:0]  bank;
        logic [12:0] addr;
    } exp_t;
    exp_t exp_q[$];

    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4, REF = 3'd5;

    always #2 clk = ~clk;

    sdram_cmd_timer u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
        .req_bank(req_bank), .req_addr(req_addr), .mem_cmd(mem_cmd),
        .mem_bank(mem_bank), .mem_addr(mem_addr), .mem_bank_sel(mem_bank_sel),
        .config_error(config_error)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: every strobe cycle pops one expected command
    always @(negedge clk) begin
        if (!rst && mem_bank_sel) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 strobe without command", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(mem_cmd == e.cmd,   "R7 cmd at strobe",  mem_cmd,  e.cmd);
                check(mem_bank == e.bank, "R7 bank at strobe", mem_bank, e.bank);
                check(mem_addr == e.addr, "R7 addr at strobe", mem_addr, e.addr);
            end
        end
    end

    task automatic write_cfg(input logic [9:0] val);
        cfg_wr = 1'b1;
        cfg_wdata = val;
        @(posedge clk);
        lead_mode = val[9];
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Called at a negedge; returns at the negedge after acceptance
    task automatic send(input logic [2:0] cmd, input logic [1:0] bank, input logic [12:0] addr,
                        input int exp_stall, input string req,
                        input bit with_cfg = 1'b0, input logic [9:0] cfg_val = '0);
        int   stall;
        logic lead;
        exp_t e;
        lead = lead_mode;
        req_valid = 1'b1;
        req_cmd = cmd;
        req_bank = bank;
        req_addr = addr;
        if (with_cfg) begin
            cfg_wr = 1'b1;
            cfg_wdata = cfg_val;
        end
        stall = 0;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
            stall++;
        end
        e.cmd = cmd; e.bank = bank; e.addr = addr;
        exp_q.push_back(e);
        @(posedge clk);
        if (with_cfg) lead_mode = cfg_val[9];
        @(negedge clk);
        req_valid = 1'b0;
        req_cmd = NOP;
        cfg_wr = 1'b0;
        check(stall == exp_stall, req, stall, exp_stall);
        check(mem_cmd == cmd, "R6 cmd on pins after accept", mem_cmd, cmd);
        check(mem_bank_sel == !lead, "R6 strobe timing", mem_bank_sel, !lead);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(req_ready == 1'b1,    "R1 ready after reset",  req_ready, 1);
        check(mem_cmd == NOP,       "R1 NOP after reset",    mem_cmd, NOP);
        check(mem_bank_sel == 1'b0, "R1 strobe low",         mem_bank_sel, 0);
        check(config_error == 1'b0, "R1 no error",           config_error, 0);
        @(negedge clk);

        // Reset word: ref 4, act2rw 2, rw2pre 1, pre2act 1
        send(REF, 2'd0, 13'h000, 0, "R3 refresh free");
        send(ACT, 2'd0, 13'h123, 3, "R3 ref->act 4 cycles");
        send(RD,  2'd0, 13'h010, 1, "R2 act->rd 2 cycles");
        send(PRE, 2'd0, 13'h400, 0, "R4 rd->pre 1 cycle");
        send(ACT, 2'd0, 13'h0AA, 0, "R5 pre->act 1 cycle");
        idle(12);

        // ref 10, act2rw 4, rw2pre 4, pre2act 3
        write_cfg(10'b0_10_11_11_110);
        idle(12);
        send(REF, 2'd0, 13'h000, 0, "R3 refresh");
        send(ACT, 2'd1, 13'h111, 9, "R3 ref->act 10 cycles");
        send(ACT, 2'd2, 13'h222, 0, "R2 other bank act free");
        send(WR,  2'd1, 13'h031, 2, "R2 act->wr 4 cycles bank1");
        send(RD,  2'd2, 13'h032, 0, "R2 bank2 independent");
        send(PRE, 2'd1, 13'h000, 3, "R4 rd->pre 4 cycles");
        send(ACT, 2'd1, 13'h1F0, 2, "R5 pre->act 3 cycles");
        idle(12);
        check(mem_cmd == NOP && mem_bank_sel == 1'b0, "R7 idle NOP", mem_cmd, NOP);

        // Leadoff 1 with short spacings
        write_cfg(10'b1_00_00_01_000);
        idle(12);
        send(ACT, 2'd3, 13'h1ABC, 0, "R6 first cmd with leadoff");
        send(RD,  2'd3, 13'h0005, 1, "R6 hold stall rd");
        send(WR,  2'd3, 13'h0006, 1, "R6 hold stall wr");
        send(PRE, 2'd3, 13'h0007, 1, "R6 hold stall pre");
        idle(3);
        check(mem_cmd == NOP && mem_bank_sel == 1'b0, "R7 NOP after leadoff", mem_cmd, NOP);

        // Reserved codes
        write_cfg(10'b0_00_00_01_111);
        check(config_error == 1'b1, "R8 ref2act 111 flagged", config_error, 1);
        req_valid = 1'b1; req_cmd = REF;
        for (int i = 0; i < 3; i++) begin
            #1;
            check(req_ready == 1'b0, "R8 ready low on error", req_ready, 0);
            @(negedge clk);
            check(mem_cmd == NOP, "R8 no issue on error", mem_cmd, NOP);
        end
        req_valid = 1'b0; req_cmd = NOP;
        idle(3);
        check(config_error == 1'b1, "R8 error sticky", config_error, 1);
        write_cfg(10'b0_00_00_00_000);
        check(config_error == 1'b1, "R8 act2rw 00 flagged", config_error, 1);
        write_cfg(10'b0_00_00_01_000);
        #1;
        check(config_error == 1'b0, "R8 clean write clears", config_error, 0);
        check(req_ready == 1'b1,    "R8 ready restored",     req_ready, 1);
        @(negedge clk);

        // Same-edge write and accept
        write_cfg(10'b0_00_00_11_000);
        idle(6);
        send(ACT, 2'd2, 13'h0222, 0, "R9 act with concurrent write", 1'b1, 10'b0_00_00_01_000);
        send(RD,  2'd2, 13'h0033, 3, "R9 old act2rw used");
        send(ACT, 2'd1, 13'h0444, 0, "R9 act after write");
        send(RD,  2'd1, 13'h0044, 1, "R9 new act2rw used");
        check(config_error == 1'b0, "R9 no error", config_error, 0);
        idle(4);
        check(exp_q.size() == 0, "R7 every command strobed", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule